// File: doc/BRIEF.md
# Staged Fast-Acquisition Sequencer for a Pulse-per-Second Loop

This block steers how quickly a timing loop settles onto a once-per-second reference. Every reference pulse event brings a signed period-difference sample and a signed phase-error sample. The block uses these samples to step through a fixed series of stages:

- a coarse phase that averages the frequency error, pulls the frequency, validates the frequency against a threshold, and pulls the phase;
- a fine phase made of four timed rapid-lock stages, each with its own loop gains;
- a final normal-lock stage, where the steady-state gains are restored and lock is reported.

The loop filter arithmetic and the oscillator sit outside this block. They use three of its outputs: the current stage, the feed-forward and integrating coefficients for that stage, and the running sum of period differences collected during averaging.

All counts, thresholds and gains are held in a small write-only configuration set. This set can be written only while the sequencer is disabled. Dropping the enable, or raising the loss-of-reference input, returns the sequencer to idle at once. An option bit lets acquisition start without waiting for an auxiliary reference loop to report lock.

Top module: `pps_acq_seq`

## Requirements
- R1: After reset the stage output is 0 (idle), locked is low, both coefficients are 0, and the frequency sum is 0.
- R2: Once enabled, the sequencer leaves idle and waits in stage 1. It moves to stage 2 (averaging) when aux_locked is high, or when bit 31 of configuration word 0 (the skip-wait option) is set. Stage 2 is entered on the next clock after either condition holds.
- R3: Stage 2 adds per_diff of each event into freq_sum. After the number of events in word 0 bits [7:0] (0 acts as 1), it moves to stage 3.
- R4: Stage 3 (frequency pull) lasts exactly 2^N events, where N is word 0 bits [10:8]. It then moves to stage 4.
- R5: Stage 4 (frequency validation) counts consecutive events with |per_diff| strictly below the frequency threshold (word 1). Any event at or above the threshold restarts this count. When the count reaches word 0 bits [23:16] (0 acts as 1), the sequencer moves to stage 5.
- R6: Stage 5 (phase pull) runs in windows of 2^N events, where N is word 0 bits [28:24]. On the last event of a window it moves on only if |ph_err| is strictly below the phase threshold (word 2). Otherwise a new window starts.
- R7: Rapid-lock stages 6 to 9 follow in order. Each uses the configuration word 4+k for k = 0..3:
  - bits [15:0] give the number of events spent in the stage;
  - bits [19:16] give the feed-forward coefficient;
  - bits [28:24] give the integrating coefficient.
  A stage whose event count is 0 is skipped in the same cycle.
- R8: Stage 10 (normal lock) outputs the coefficients in word 3 (bits [3:0] feed-forward, bits [12:8] integrating) and raises locked. Stages 0 to 5 output zero coefficients, and locked rises only on an event.
- R9: When en is low or ref_lost is high, the sequencer is in stage 0 with locked low on the next clock.
- R10: A configuration write (cfg_we with cfg_addr selecting words 0 to 7) takes effect only while en is low. Writes made while enabled leave the outputs unchanged.
- R11: In stages 2 to 9 the stage changes only on an event, and it never steps backwards except to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Sequencer enable |
| ref_lost | input | 1 | Reference loss; forces idle |
| aux_locked | input | 1 | Auxiliary reference loop lock indication |
| evt | input | 1 | One-cycle reference pulse event strobe |
| per_diff | input | MW | Signed period difference for this event |
| ph_err | input | MW | Signed phase error for this event |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| stage | output | 4 | Current stage code |
| ff_coef | output | 4 | Active feed-forward coefficient |
| int_coef | output | 5 | Active integrating coefficient |
| locked | output | 1 | High in normal-lock stage |
| freq_sum | output | SW | Sum of period differences from averaging |

## Verification
Stage is a register that updates on the clock edge where evt is sampled. The coefficients and locked are decoded from that register without further delay, so every result of an event is due one clock after the strobe.

The bench drives each strobe for one cycle from a falling edge and samples all outputs at the following falling edge. Changes to enable and loss of reference take effect on the next edge. A configuration write lands one edge after its strobe.

Leaving the wait stage takes one edge after the auxiliary lock or skip condition holds. The bench therefore reads the stage at the falling edge after that rising edge.

// File: rtl/acq_pkg.sv
package acq_pkg;

    localparam int N_RL = 4;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_WAIT_AUX = 4'd1,
        ST_FAVG     = 4'd2,
        ST_FPULL    = 4'd3,
        ST_FVAL     = 4'd4,
        ST_PPULL    = 4'd5,
        ST_RL0      = 4'd6,
        ST_RL1      = 4'd7,
        ST_RL2      = 4'd8,
        ST_RL3      = 4'd9,
        ST_NORM     = 4'd10
    } stage_e;

    typedef struct packed {
        logic [15:0] hold;
        logic [3:0]  ff;
        logic [4:0]  integ;
    } rl_cfg_t;

    typedef struct packed {
        logic                   skip_aux;
        logic [7:0]             avg_n;
        logic [2:0]             fp_log2;
        logic [7:0]             fv_n;
        logic [4:0]             pp_log2;
        logic [3:0]             nl_ff;
        logic [4:0]             nl_int;
        rl_cfg_t [N_RL-1:0]     rl;
    } seq_cfg_t;

    function automatic stage_e rl_stage(input int idx);
        return stage_e'(4'(int'(ST_RL0) + idx));
    endfunction

    // first rapid stage at or after 'from' whose hold count is nonzero
    function automatic stage_e next_rl(input logic [N_RL-1:0] live, input int from);
        stage_e r;
        r = ST_NORM;
        for (int i = N_RL - 1; i >= 0; i--) begin
            if (i >= from && live[i]) r = rl_stage(i);
        end
        return r;
    endfunction

    // true when this event closes a window of 2^lg events
    function automatic logic pow2_done(input logic [31:0] cnt, input logic [4:0] lg);
        return ({1'b0, cnt} + 33'd1) == (33'd1 << lg);
    endfunction

endpackage

// File: rtl/acq_cfg_regs.sv
module acq_cfg_regs
    import acq_pkg::*;
#(
    parameter int TW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          we,
    input  logic [2:0]    addr,
    input  logic [31:0]   wdata,
    output seq_cfg_t      cfg,
    output logic [TW-1:0] f_thr,
    output logic [TW-1:0] p_thr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            f_thr <= '0;
            p_thr <= '0;
        end else if (we && !en) begin
            case (addr)
                3'd0: begin
                    cfg.avg_n    <= wdata[7:0];
                    cfg.fp_log2  <= wdata[10:8];
                    cfg.fv_n     <= wdata[23:16];
                    cfg.pp_log2  <= wdata[28:24];
                    cfg.skip_aux <= wdata[31];
                end
                3'd1: f_thr <= wdata[TW-1:0];
                3'd2: p_thr <= wdata[TW-1:0];
                3'd3: begin
                    cfg.nl_ff  <= wdata[3:0];
                    cfg.nl_int <= wdata[12:8];
                end
                default: begin
                    cfg.rl[addr[1:0]].hold  <= wdata[15:0];
                    cfg.rl[addr[1:0]].ff    <= wdata[19:16];
                    cfg.rl[addr[1:0]].integ <= wdata[28:24];
                end
            endcase
        end
    end

endmodule

// File: rtl/acq_mag_cmp.sv
module acq_mag_cmp #(
    parameter int W = 24
) (
    input  logic signed [W-1:0] val,
    input  logic        [W-1:0] thr,
    output logic                below
);

    logic [W:0] mag;

    always_comb begin
        if (val[W-1]) mag = (W+1)'(-{val[W-1], val});
        else          mag = {1'b0, val};
        below = mag < {1'b0, thr};
    end

endmodule

// File: rtl/acq_stage_fsm.sv
module acq_stage_fsm
    import acq_pkg::*;
#(
    parameter int MW = 24,
    parameter int SW = MW + 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic                 aux_ok,
    input  logic                 evt,
    input  logic signed [MW-1:0] per_diff,
    input  logic                 f_below,
    input  logic                 p_below,
    input  seq_cfg_t             cfg,
    output stage_e               stage_q,
    output logic signed [SW-1:0] sum_q
);

    logic [31:0]     cnt_q;
    logic [31:0]     cnt_nxt;
    logic [7:0]      streak_q;
    logic [7:0]      avg_lim;
    logic [7:0]      fv_lim;
    logic [1:0]      rl_idx;
    logic [15:0]     hold_sel;
    logic [N_RL-1:0] live;

    for (genvar g = 0; g < N_RL; g++) begin : g_live
        assign live[g] = |cfg.rl[g].hold;
    end

    always_comb begin
        cnt_nxt  = cnt_q + 32'd1;
        avg_lim  = (cfg.avg_n == 8'd0) ? 8'd1 : cfg.avg_n;
        fv_lim   = (cfg.fv_n == 8'd0) ? 8'd1 : cfg.fv_n;
        rl_idx   = 2'(stage_q - ST_RL0);
        hold_sel = cfg.rl[rl_idx].hold;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            stage_q  <= ST_IDLE;
            cnt_q    <= '0;
            streak_q <= '0;
            sum_q    <= '0;
        end else begin
            case (stage_q)
                ST_IDLE: stage_q <= ST_WAIT_AUX;
                ST_WAIT_AUX: begin
                    if (cfg.skip_aux || aux_ok) begin
                        stage_q <= ST_FAVG;
                        cnt_q   <= '0;
                        sum_q   <= '0;
                    end
                end
                ST_FAVG: begin
                    if (evt) begin
                        sum_q <= sum_q + SW'(per_diff);
                        if (cnt_nxt >= {24'd0, avg_lim}) begin
                            stage_q <= ST_FPULL;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_nxt;
                        end
                    end
                end
                ST_FPULL: begin
                    if (evt) begin
                        if (pow2_done(cnt_q, {2'b00, cfg.fp_log2})) begin
                            stage_q  <= ST_FVAL;
                            cnt_q    <= '0;
                            streak_q <= '0;
                        end else begin
                            cnt_q <= cnt_nxt;
                        end
                    end
                end
                ST_FVAL: begin
                    if (evt) begin
                        if (f_below) begin
                            if (({1'b0, streak_q} + 9'd1) >= {1'b0, fv_lim}) begin
                                stage_q <= ST_PPULL;
                                cnt_q   <= '0;
                            end else begin
                                streak_q <= streak_q + 8'd1;
                            end
                        end else begin
                            streak_q <= '0;
                        end
                    end
                end
                ST_PPULL: begin
                    if (evt) begin
                        if (pow2_done(cnt_q, cfg.pp_log2)) begin
                            cnt_q <= '0;
                            if (p_below) stage_q <= next_rl(live, 0);
                        end else begin
                            cnt_q <= cnt_nxt;
                        end
                    end
                end
                ST_RL0, ST_RL1, ST_RL2, ST_RL3: begin
                    if (evt) begin
                        if (cnt_nxt >= {16'd0, hold_sel}) begin
                            stage_q <= next_rl(live, int'(rl_idx) + 1);
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_nxt;
                        end
                    end
                end
                ST_NORM: stage_q <= ST_NORM;
                default: stage_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pps_acq_seq.sv
module pps_acq_seq
    import acq_pkg::*;
#(
    parameter int MW = 24,
    parameter int TW = MW,
    parameter int SW = MW + 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 ref_lost,
    input  logic                 aux_locked,
    input  logic                 evt,
    input  logic signed [MW-1:0] per_diff,
    input  logic signed [MW-1:0] ph_err,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_addr,
    input  logic [31:0]          cfg_wdata,
    output logic [3:0]           stage,
    output logic [3:0]           ff_coef,
    output logic [4:0]           int_coef,
    output logic                 locked,
    output logic signed [SW-1:0] freq_sum
);

    seq_cfg_t      cfg;
    logic [TW-1:0] f_thr;
    logic [TW-1:0] p_thr;
    logic          f_below;
    logic          p_below;
    stage_e        st;
    logic [1:0]    sel;

    acq_cfg_regs #(.TW(TW)) u_cfg (
        .clk(clk), .rst(rst), .en(en), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .cfg(cfg), .f_thr(f_thr), .p_thr(p_thr)
    );

    acq_mag_cmp #(.W(MW)) u_fcmp (
        .val(per_diff), .thr(MW'(f_thr)), .below(f_below)
    );

    acq_mag_cmp #(.W(MW)) u_pcmp (
        .val(ph_err), .thr(MW'(p_thr)), .below(p_below)
    );

    acq_stage_fsm #(.MW(MW), .SW(SW)) u_fsm (
        .clk(clk), .rst(rst), .run(en && !ref_lost), .aux_ok(aux_locked),
        .evt(evt), .per_diff(per_diff), .f_below(f_below), .p_below(p_below),
        .cfg(cfg), .stage_q(st), .sum_q(freq_sum)
    );

    always_comb begin
        sel      = 2'(st - ST_RL0);
        ff_coef  = '0;
        int_coef = '0;
        case (st)
            ST_RL0, ST_RL1, ST_RL2, ST_RL3: begin
                ff_coef  = cfg.rl[sel].ff;
                int_coef = cfg.rl[sel].integ;
            end
            ST_NORM: begin
                ff_coef  = cfg.nl_ff;
                int_coef = cfg.nl_int;
            end
            default: ;
        endcase
    end

    assign stage  = st;
    assign locked = (st == ST_NORM);

endmodule

// File: rtl/acq_seq_chk.sv
module acq_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       ref_lost,
    input logic       evt,
    input logic [3:0] stage,
    input logic [3:0] ff_coef,
    input logic [4:0] int_coef,
    input logic       locked
);

    assert_idle_on_stop_R9: assert property (@(posedge clk) disable iff (rst)
        (!en || ref_lost) |=> (stage == 4'd0 && !locked));

    assert_move_needs_event_R11: assert property (@(posedge clk) disable iff (rst)
        (en && !ref_lost && stage >= 4'd2 && stage <= 4'd9 && !evt) |=> $stable(stage));

    assert_forward_only_R11: assert property (@(posedge clk) disable iff (rst)
        (en && !ref_lost) |=> (stage >= $past(stage)));

    assert_lock_on_event_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(evt));

    assert_gains_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (locked && en && !ref_lost) |=> ($stable(ff_coef) && $stable(int_coef)));

endmodule

bind pps_acq_seq acq_seq_chk i_chk (
    .clk(clk), .rst(rst), .en(en), .ref_lost(ref_lost), .evt(evt),
    .stage(stage), .ff_coef(ff_coef), .int_coef(int_coef), .locked(locked)
);

// File: tb/test_pps_acq_seq.sv
module test_pps_acq_seq;

    localparam int MW = 24;
    localparam int SW = MW + 8;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 en = 1'b0;
    logic                 ref_lost = 1'b0;
    logic                 aux_locked = 1'b0;
    logic                 evt = 1'b0;
    logic signed [MW-1:0] per_diff = '0;
    logic signed [MW-1:0] ph_err = '0;
    logic                 cfg_we = 1'b0;
    logic [2:0]           cfg_addr = '0;
    logic [31:0]          cfg_wdata = '0;
    logic [3:0]           stage;
    logic [3:0]           ff_coef;
    logic [4:0]           int_coef;
    logic                 locked;
    logic signed [SW-1:0] freq_sum;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    pps_acq_seq i_pps_acq_seq (
        .clk(clk), .rst(rst), .en(en), .ref_lost(ref_lost), .aux_locked(aux_locked),
        .evt(evt), .per_diff(per_diff), .ph_err(ph_err), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .stage(stage), .ff_coef(ff_coef),
        .int_coef(int_coef), .locked(locked), .freq_sum(freq_sum)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input int pd, input int pe);
        @(negedge clk);
        evt = 1'b1; per_diff = MW'(pd); ph_err = MW'(pe);
        @(negedge clk);
        evt = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(1);
        chk("R1 stage", 32'(stage), 0);
        chk("R1 locked", 32'(locked), 0);
        chk("R1 ff", 32'(ff_coef), 0);
        chk("R1 int", 32'(int_coef), 0);
        chk("R1 sum", 32'(freq_sum), 0);
    endtask

    task automatic t_full_run;
        wr(3'd0, 32'h8103_0203);   // avg 3, fp 2^2, fv 3, pp 2^1, skip wait
        wr(3'd1, 32'd5);
        wr(3'd2, 32'd50);
        wr(3'd3, 32'h0000_1307);   // ff 7, int 19
        wr(3'd4, 32'h0301_0002);
        wr(3'd5, 32'h0402_0000);
        wr(3'd6, 32'h0503_0001);
        wr(3'd7, 32'h0604_0000);
        aux_locked = 1'b0;
        @(negedge clk); en = 1'b1;
        idle(2);
        chk("R2 skip wait", 32'(stage), 2);
        pulse(10, 0); pulse(-4, 0);
        chk("R3 averaging", 32'(stage), 2);
        pulse(7, 0);
        chk("R3 to fpull", 32'(stage), 3);
        chk("R3 sum", 32'(freq_sum), 13);
        chk("R8 zero gains early", 32'(ff_coef), 0);
        pulse(0, 0); pulse(0, 0);
        idle(5);
        chk("R11 no move w/o event", 32'(stage), 3);
        pulse(0, 0);
        chk("R4 fpull length", 32'(stage), 3);
        pulse(0, 0);
        chk("R4 to fval", 32'(stage), 4);
        pulse(2, 0); pulse(3, 0); pulse(-5, 0);
        pulse(1, 0); pulse(-2, 0);
        chk("R5 streak restarted", 32'(stage), 4);
        pulse(4, 0);
        chk("R5 to ppull", 32'(stage), 5);
        pulse(0, 0); pulse(0, 100);
        chk("R6 window fails", 32'(stage), 5);
        pulse(0, 3); pulse(0, 50);
        chk("R6 threshold strict", 32'(stage), 5);
        pulse(0, 0); pulse(0, -49);
        chk("R6 to rl0", 32'(stage), 6);
        chk("R7 rl0 ff", 32'(ff_coef), 1);
        chk("R7 rl0 int", 32'(int_coef), 3);
        pulse(0, 0);
        chk("R7 rl0 hold", 32'(stage), 6);
        pulse(0, 0);
        chk("R7 skip rl1", 32'(stage), 8);
        chk("R7 rl2 ff", 32'(ff_coef), 3);
        chk("R7 rl2 int", 32'(int_coef), 5);
        pulse(0, 0);
        chk("R7 skip rl3", 32'(stage), 10);
        chk("R8 locked", 32'(locked), 1);
        chk("R8 nl ff", 32'(ff_coef), 7);
        chk("R8 nl int", 32'(int_coef), 19);
        wr(3'd3, 32'h0000_0102);
        chk("R10 ff unchanged", 32'(ff_coef), 7);
        chk("R10 int unchanged", 32'(int_coef), 19);
        @(negedge clk); ref_lost = 1'b1;
        @(negedge clk); ref_lost = 1'b0;
        chk("R9 ref lost stage", 32'(stage), 0);
        chk("R9 ref lost locked", 32'(locked), 0);
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        chk("R9 disabled", 32'(stage), 0);
    endtask

    task automatic t_zero_counts;
        wr(3'd0, 32'h0000_0000);   // all counts 0, wait for aux
        wr(3'd3, 32'h0000_0102);   // ff 2, int 1
        for (int k = 4; k < 8; k++) wr(3'(k), 32'h0101_0000);
        aux_locked = 1'b0;
        @(negedge clk); en = 1'b1;
        idle(4);
        chk("R2 waits for aux", 32'(stage), 1);
        pulse(9, 0);
        chk("R2 event ignored in wait", 32'(stage), 1);
        @(negedge clk); aux_locked = 1'b1;
        @(negedge clk);
        chk("R2 aux releases", 32'(stage), 2);
        pulse(6, 0);
        chk("R3 zero acts as one", 32'(stage), 3);
        chk("R3 sum single", 32'(freq_sum), 6);
        pulse(0, 0);
        chk("R4 one event", 32'(stage), 4);
        pulse(0, 0);
        chk("R5 zero acts as one", 32'(stage), 5);
        pulse(0, 0);
        chk("R7 all skipped", 32'(stage), 10);
        chk("R10 new nl ff", 32'(ff_coef), 2);
        chk("R10 new nl int", 32'(int_coef), 1);
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        chk("R9 en low", 32'(stage), 0);
        chk("R9 en low locked", 32'(locked), 0);
    endtask

    initial begin
        t_reset;
        t_full_run;
        t_zero_counts;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule